// File: doc/BRIEF.md
# AES Round-Key Expansion Unit

This block turns an AES cipher key of 128, 192 or 256 bits into the complete set of round keys. It stores those round keys for a cipher core to read. A setup run starts with a one-cycle start pulse that also selects the key size. The key then arrives in 64-bit chunks. After the last chunk, the unit produces two new 32-bit schedule words on every clock until the whole schedule is written into an internal store. It then raises a ready flag.

Key size does not change the datapath. The most recent eight schedule words sit in one shift chain, and the key size only picks which two words of that chain are tapped as the words lying one key length back. In each cycle the first new word may pass through the rotate/substitute/round-constant path, or through the substitute-only path that 256-bit keys need. The second new word is formed from the first one in the same cycle.

Once ready, the cipher core reads one 128-bit round key per round index through a combinational read port.

Top module: `aes_rkey_gen`

## Requirements
- R1: `key_size_i` is sampled in the cycle `start_i` is high. The encoding is 0 = 128-bit (Nk=4, Nr=10), 1 = 192-bit (Nk=6, Nr=12) and 2 = 256-bit (Nk=8, Nr=14). Code 3 behaves exactly like code 0.
- R2: `ready_o` is low in the cycle after any cycle with `start_i` high. A start pulse abandons any setup in progress and begins a new load.
- R3: After a start pulse the unit takes exactly Nk/2 chunks, one on each clock edge that sees `key_valid_i` high; cycles with `key_valid_i` low are waited out. In each chunk, bits 63:32 hold the earlier key word and bits 31:0 the next one. The first chunk carries words 0 and 1.
- R4: Schedule words follow the standard recurrence. Let i be the word index. If i mod Nk = 0, then W[i] = W[i-Nk] xor SubWord(RotWord(W[i-1])) xor {Rcon, 24'h0}, where Rcon starts at 8'h01 and is doubled in GF(2^8) (reduce by 8'h1B) after each use. Otherwise W[i] = W[i-Nk] xor W[i-1].
- R5: For 256-bit keys, a word with i mod 8 = 4 is W[i-8] xor SubWord(W[i-1]), with no rotation and no round constant.
- R6: `ready_o` rises exactly 20, 23 or 26 clock edges (for 128, 192 or 256 bits) after the edge that accepts the last key chunk. It then stays high until the next start pulse.
- R7: `rd_key_o` presents words 4r..4r+3 for `rd_idx_i` = r, with word 4r in bits 127:96 and word 4r+3 in bits 31:0. It follows `rd_idx_i` combinationally.
- R8: An index greater than Nr gives an all-zero `rd_key_o`.
- R9: Outside the load phase, `key_valid_i` and `key_data_i` have no effect: the stored round keys and `ready_o` do not change.
- R10: After reset, `ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a new setup run |
| key_size_i | input | 2 | Key size code, sampled with start |
| key_valid_i | input | 1 | Key chunk valid |
| key_data_i | input | 64 | Key chunk, earlier word in upper half |
| rd_idx_i | input | 4 | Round index to read |
| rd_key_o | output | 128 | Round key for rd_idx_i |
| ready_o | output | 1 | All round keys stored |

## Verification
The bench runs the published 128-bit and 256-bit example keys, whose final round keys are known constants, alongside seeded random keys of every size. The known constants catch mistakes in the S-box, the round constants and the word order. The random keys catch tap-selection errors that only show up in particular words. The 256-bit keys exercise the substitute-only step that the other sizes never use. Key chunks are also sent with idle gaps, a start is issued in the middle of an expansion, and size code 3 is loaded. These cases separate correct load counting, restart handling and size decoding from a unit that happens to work only on back-to-back input. Stray chunks after ready and out-of-range indices show whether the store is protected and whether the zero path is correct.

// File: rtl/aes_rkey_pkg.sv
package aes_rkey_pkg;
  localparam int WORD_W    = 32;
  localparam int PAIR_W    = 2 * WORD_W;
  localparam int CHAIN_LEN = 8;
  localparam int MAX_PAIRS = 30;
  localparam int PTR_W     = $clog2(MAX_PAIRS + 1);
  localparam int IDX_W     = 4;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_EXPAND = 2'd2,
    ST_DONE   = 2'd3
  } kst_e;

  function automatic logic [3:0] nk_of(input logic [1:0] sz);
    case (sz)
      2'd1:    nk_of = 4'd6;
      2'd2:    nk_of = 4'd8;
      default: nk_of = 4'd4;
    endcase
  endfunction

  function automatic logic [3:0] nr_of(input logic [1:0] sz);
    nr_of = nk_of(sz) + 4'd6;
  endfunction

  function automatic logic [PTR_W-1:0] pairs_of(input logic [1:0] sz);
    pairs_of = PTR_W'({1'b0, nr_of(sz)} + 5'd1) << 1;
  endfunction

  function automatic logic [7:0] xtime(input logic [7:0] b);
    xtime = {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction
endpackage

// File: rtl/aes_rkey_sbox.sv
module aes_rkey_sbox (
  input  logic [7:0] a_i,
  output logic [7:0] s_o
);
  function automatic logic [7:0] gmul(input logic [7:0] x, input logic [7:0] y);
    logic [7:0] acc;
    logic [7:0] t;
    acc = 8'h00;
    t   = x;
    for (int k = 0; k < 8; k++) begin
      if (y[k]) acc = acc ^ t;
      t = {t[6:0], 1'b0} ^ (t[7] ? 8'h1b : 8'h00);
    end
    return acc;
  endfunction

  logic [7:0] inv;

  // multiplicative inverse as a^254 by square-and-multiply
  always_comb begin
    logic [7:0] base;
    logic [7:0] r;
    base = a_i;
    r    = 8'h01;
    for (int k = 0; k < 8; k++) begin
      if (k != 0) r = gmul(r, base);
      base = gmul(base, base);
    end
    inv = r;
  end

  assign s_o = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
             ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
endmodule

// File: rtl/aes_rkey_xform.sv
module aes_rkey_xform
  import aes_rkey_pkg::*;
(
  input  word_t      prev_i,
  input  logic       rot_en_i,
  input  logic [7:0] rcon_i,
  output word_t      out_o
);
  localparam int NBYTES = WORD_W / 8;

  word_t      rotated;
  word_t      subbed;
  logic [7:0] rcon_eff;

  assign rotated  = rot_en_i ? {prev_i[WORD_W-9:0], prev_i[WORD_W-1 -: 8]} : prev_i;
  assign rcon_eff = rot_en_i ? rcon_i : 8'h00;

  for (genvar b = 0; b < NBYTES; b++) begin : g_sub
    aes_rkey_sbox u_sbox (
      .a_i (rotated[8*b +: 8]),
      .s_o (subbed[8*b +: 8])
    );
  end

  assign out_o = subbed ^ {rcon_eff, {(WORD_W-8){1'b0}}};
endmodule

// File: rtl/aes_rkey_store.sv
module aes_rkey_store #(
  parameter int DEPTH  = 30,
  parameter int PAIR_W = 64,
  parameter int PTR_W  = 5,
  parameter int IDX_W  = 4
) (
  input  logic                clk,
  input  logic                we_i,
  input  logic [PTR_W-1:0]    waddr_i,
  input  logic [PAIR_W-1:0]   wdata_i,
  input  logic [IDX_W-1:0]    ridx_i,
  output logic [2*PAIR_W-1:0] rdata_o
);
  localparam int RA_W = IDX_W + 1;

  logic [PAIR_W-1:0] mem_q [DEPTH];
  logic [RA_W-1:0]   ra0;
  logic [RA_W-1:0]   ra1;

  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign ra0 = {ridx_i, 1'b0};
  assign ra1 = {ridx_i, 1'b1};

  always_comb begin
    rdata_o = '0;
    if (int'(ra1) < DEPTH) rdata_o = {mem_q[ra0], mem_q[ra1]};
  end
endmodule

// File: rtl/aes_rkey_gen.sv
module aes_rkey_gen
  import aes_rkey_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [1:0]            key_size_i,
  input  logic                  key_valid_i,
  input  logic [PAIR_W-1:0]     key_data_i,
  input  logic [IDX_W-1:0]      rd_idx_i,
  output logic [2*PAIR_W-1:0]   rd_key_o,
  output logic                  ready_o
);
  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_n    <= rst_meta_q;
    end
  end

  kst_e             st_q, st_d;
  logic [1:0]       sz_q, sz_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [3:0]       pos_q, pos_d;
  logic [7:0]       rcon_q, rcon_d;
  logic             ready_q, ready_d;
  word_t            chain_q [CHAIN_LEN];

  logic [3:0]       nk_w, nr_w, half_nk;
  logic [PTR_W-1:0] pairs_w;
  logic             chain_en, we;
  logic [PAIR_W-1:0] push;
  word_t            tap_a, tap_b, xf_out, fa, wa, wb;
  logic             rot_en, sub_only;

  assign nk_w    = nk_of(sz_q);
  assign nr_w    = nr_of(sz_q);
  assign pairs_w = pairs_of(sz_q);
  assign half_nk = nk_w >> 1;

  // taps one key length back, picked by size
  always_comb begin
    case (sz_q)
      2'd1:    begin tap_a = chain_q[5]; tap_b = chain_q[4]; end
      2'd2:    begin tap_a = chain_q[7]; tap_b = chain_q[6]; end
      default: begin tap_a = chain_q[3]; tap_b = chain_q[2]; end
    endcase
  end

  assign rot_en   = (pos_q == 4'd0);
  assign sub_only = (sz_q == 2'd2) && (pos_q == 4'd4);

  aes_rkey_xform u_xform (
    .prev_i   (chain_q[0]),
    .rot_en_i (rot_en),
    .rcon_i   (rcon_q),
    .out_o    (xf_out)
  );

  assign fa = (rot_en || sub_only) ? xf_out : chain_q[0];
  assign wa = tap_a ^ fa;
  assign wb = tap_b ^ wa;

  // next state
  always_comb begin
    st_d     = st_q;
    sz_d     = sz_q;
    ptr_d    = ptr_q;
    pos_d    = pos_q;
    rcon_d   = rcon_q;
    ready_d  = ready_q;
    chain_en = 1'b0;
    we       = 1'b0;
    push     = {wa, wb};
    if (start_i) begin
      st_d    = ST_LOAD;
      sz_d    = (key_size_i == 2'd3) ? 2'd0 : key_size_i;
      ptr_d   = '0;
      ready_d = 1'b0;
    end else begin
      case (st_q)
        ST_LOAD: begin
          if (key_valid_i) begin
            chain_en = 1'b1;
            we       = 1'b1;
            push     = key_data_i;
            ptr_d    = ptr_q + 1'b1;
            if (ptr_q == PTR_W'(half_nk - 4'd1)) begin
              st_d   = ST_EXPAND;
              pos_d  = 4'd0;
              rcon_d = 8'h01;
            end
          end
        end
        ST_EXPAND: begin
          chain_en = 1'b1;
          we       = 1'b1;
          ptr_d    = ptr_q + 1'b1;
          pos_d    = ((pos_q + 4'd2) == nk_w) ? 4'd0 : pos_q + 4'd2;
          if (rot_en) rcon_d = xtime(rcon_q);
          if (ptr_q == pairs_w - 1'b1) begin
            st_d    = ST_DONE;
            ready_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q    <= ST_IDLE;
      sz_q    <= 2'd0;
      ptr_q   <= '0;
      pos_q   <= 4'd0;
      rcon_q  <= 8'h01;
      ready_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      sz_q    <= sz_d;
      ptr_q   <= ptr_d;
      pos_q   <= pos_d;
      rcon_q  <= rcon_d;
      ready_q <= ready_d;
    end
  end

  // word chain: newest word at index 0
  always_ff @(posedge clk) begin
    if (chain_en) begin
      chain_q[0] <= push[WORD_W-1:0];
      chain_q[1] <= push[PAIR_W-1:WORD_W];
      for (int k = 2; k < CHAIN_LEN; k++) chain_q[k] <= chain_q[k-2];
    end
  end

  logic [2*PAIR_W-1:0] store_rd;

  aes_rkey_store #(
    .DEPTH  (MAX_PAIRS),
    .PAIR_W (PAIR_W),
    .PTR_W  (PTR_W),
    .IDX_W  (IDX_W)
  ) u_store (
    .clk     (clk),
    .we_i    (we),
    .waddr_i (ptr_q),
    .wdata_i (push),
    .ridx_i  (rd_idx_i),
    .rdata_o (store_rd)
  );

  assign rd_key_o = (rd_idx_i > nr_w) ? '0 : store_rd;
  assign ready_o  = ready_q;
endmodule

// File: rtl/aes_rkey_gen_chk.sv
module aes_rkey_gen_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         ready_o,
  input logic [3:0]   rd_idx_i,
  input logic [127:0] rd_key_o,
  input logic [4:0]   wr_ptr,
  input logic [4:0]   pairs_total,
  input logic [3:0]   nr_cur
);
  AST_READY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !ready_o); // R2
  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !start_i) |=> ready_o); // R6
  AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> (wr_ptr == pairs_total)); // R6
  AST_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && (rd_idx_i > nr_cur)) |-> (rd_key_o == '0)); // R8
  AST_STORE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !start_i) |=> (!$stable(rd_idx_i) || $stable(rd_key_o))); // R9
endmodule

bind aes_rkey_gen aes_rkey_gen_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .ready_o     (ready_o),
  .rd_idx_i    (rd_idx_i),
  .rd_key_o    (rd_key_o),
  .wr_ptr      (ptr_q),
  .pairs_total (pairs_w),
  .nr_cur      (nr_w)
);

// File: tb/aes_rkey_gen_tb_top.sv
module aes_rkey_gen_tb_top;
  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic [1:0]   key_size_i;
  logic         key_valid_i;
  logic [63:0]  key_data_i;
  logic [3:0]   rd_idx_i;
  logic [127:0] rd_key_o;
  logic         ready_o;

  int checks = 0;
  int errors = 0;
  logic [7:0]  sb [256];
  logic [31:0] rw [60];

  aes_rkey_gen dut_i (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic logic [7:0] gf(input logic [7:0] x, input logic [7:0] y);
    logic [7:0] r = 0;
    logic [7:0] a = x;
    for (int k = 0; k < 8; k++) begin
      if (y[k]) r ^= a;
      a = a[7] ? ({a[6:0], 1'b0} ^ 8'h1b) : {a[6:0], 1'b0};
    end
    return r;
  endfunction

  task automatic build_sbox();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] y = 0;
      logic [7:0] s;
      for (int c = 1; c < 256; c++) if (gf(8'(x), 8'(c)) == 8'h01) y = 8'(c);
      for (int i = 0; i < 8; i++)
        s[i] = y[i] ^ y[(i+4)%8] ^ y[(i+5)%8] ^ y[(i+6)%8] ^ y[(i+7)%8] ^ ((8'h63 >> i) & 1);
      sb[x] = s;
    end
  endtask

  function automatic logic [31:0] subw(input logic [31:0] w);
    return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
  endfunction

  task automatic ref_expand(input logic [255:0] key, input int nk);
    int tot = 4 * (nk + 7);
    logic [31:0] t;
    logic [7:0] rc = 8'h01;
    for (int i = 0; i < nk; i++) rw[i] = key[255-32*i -: 32];
    for (int i = nk; i < tot; i++) begin
      t = rw[i-1];
      if (i % nk == 0) begin
        t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = rc[7] ? ({rc[6:0], 1'b0} ^ 8'h1b) : {rc[6:0], 1'b0};
      end else if (nk == 8 && i % nk == 4) begin
        t = subw(t);
      end
      rw[i] = rw[i-nk] ^ t;
    end
  endtask

  function automatic int nk_code(input logic [1:0] sz);
    return (sz == 2'd1) ? 6 : (sz == 2'd2) ? 8 : 4;
  endfunction

  // start, load chunks (optional gaps), return edges to ready
  task automatic load_key(input logic [255:0] key, input logic [1:0] sz, input int gap, output int lat);
    int nk = nk_code(sz);
    @(negedge clk);
    start_i = 1'b1; key_size_i = sz; key_valid_i = 1'b0;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0; key_size_i = 2'($urandom);
    chk(ready_o == 1'b0, "R2 ready low after start", 128'(ready_o), 128'h0);
    for (int j = 0; j < nk/2; j++) begin
      for (int g = 0; g < gap; g++) begin
        key_valid_i = 1'b0; key_data_i = {$urandom, $urandom};
        @(posedge clk); @(negedge clk);
      end
      key_valid_i = 1'b1; key_data_i = key[255-64*j -: 64];
      @(posedge clk); @(negedge clk);
    end
    key_valid_i = 1'b0; key_data_i = {$urandom, $urandom};
    lat = 0;
    while (lat < 100) begin
      @(posedge clk); @(negedge clk);
      lat++;
      if (ready_o) break;
    end
  endtask

  task automatic check_keys(input logic [255:0] key, input logic [1:0] sz, input string tag);
    int nk = nk_code(sz);
    int nr = nk + 6;
    ref_expand(key, nk);
    for (int r = 0; r <= nr; r++) begin
      logic [127:0] e = {rw[4*r], rw[4*r+1], rw[4*r+2], rw[4*r+3]};
      rd_idx_i = 4'(r);
      #1;
      chk(rd_key_o === e, $sformatf("%s round %0d R4 R7", tag, r), rd_key_o, e);
    end
    if (nr < 15) begin
      rd_idx_i = 4'(nr + 1);
      #1;
      chk(rd_key_o === 128'h0, $sformatf("%s R8 index %0d zero", tag, nr + 1), rd_key_o, 128'h0);
    end
  endtask

  task automatic run_case(input logic [255:0] key, input logic [1:0] sz, input int gap, input string tag);
    int lat;
    int explat = (nk_code(sz) == 4) ? 20 : (nk_code(sz) == 6) ? 23 : 26;
    load_key(key, sz, gap, lat);
    chk(lat == explat, $sformatf("%s R6 R3 latency", tag), 128'(lat), 128'(explat));
    check_keys(key, sz, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [255:0] k;
    int lat;
    void'($urandom(32'd20241));
    build_sbox();
    rst_n = 1'b0; start_i = 1'b0; key_size_i = 2'd0;
    key_valid_i = 1'b0; key_data_i = '0; rd_idx_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ready_o == 1'b0, "R10 ready after reset", 128'(ready_o), 128'h0);

    // known 128-bit example
    k = {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0};
    run_case(k, 2'd0, 0, "k128 known R1");
    rd_idx_i = 4'd10; #1;
    chk(rd_key_o === 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R4 k128 final constant",
        rd_key_o, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);

    // known 256-bit example
    k = 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;
    run_case(k, 2'd2, 0, "k256 known R1");
    rd_idx_i = 4'd14; #1;
    chk(rd_key_o === 128'h24fc79ccbf0979e9371ac23c6d68de36, "R5 k256 final constant",
        rd_key_o, 128'h24fc79ccbf0979e9371ac23c6d68de36);

    // random keys of all sizes, some with gaps
    for (int n = 0; n < 9; n++) begin
      logic [1:0] sz = 2'(n % 3);
      k = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      if (sz == 2'd0) k[127:0] = '0;
      if (sz == 2'd1) k[63:0] = '0;
      run_case(k, sz, n % 3, $sformatf("rand%0d sz%0d R1 R3 R5", n, sz));
    end

    // size code 3 acts as 128
    k = {$urandom, $urandom, $urandom, $urandom, 128'h0};
    run_case(k, 2'd3, 1, "R1 code3 as 128");

    // R9: stray chunks after ready
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      key_valid_i = 1'b1; key_data_i = {$urandom, $urandom};
    end
    @(negedge clk);
    key_valid_i = 1'b0;
    chk(ready_o == 1'b1, "R9 ready kept after stray chunks", 128'(ready_o), 128'h1);
    check_keys(k, 2'd0, "R9 store unchanged");

    // R2: restart in the middle of an expansion
    k = {$urandom, $urandom, $urandom, $urandom, 128'h0};
    @(negedge clk);
    start_i = 1'b1; key_size_i = 2'd0;
    @(negedge clk);
    start_i = 1'b0;
    key_valid_i = 1'b1; key_data_i = k[255:192];
    @(negedge clk);
    key_data_i = k[191:128];
    @(negedge clk);
    key_valid_i = 1'b0;
    repeat (5) @(negedge clk);
    chk(ready_o == 1'b0, "R2 mid-expansion not ready", 128'(ready_o), 128'h0);
    k = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, 64'h0};
    run_case(k, 2'd1, 0, "R2 restart 192");

    finish_run();
  end
endmodule